// File: doc/BRIEF.md
# Flash Write-Status Reporting

This block sits on the device side of a parallel NOR-style flash. While an internal program or erase is running, it decides what a host read returns. Depending on the operation in progress, it either returns a status word or passes the array data through unchanged. An external command sequencer tells it when an operation starts, ends, aborts or is suspended. It also supplies the target sector and bit 7 of the word being programmed. The block answers every read strobe with the right polling, toggle and abort bits, and drives a ready/busy flag.

The host tells busy from finished in three ways. It reads the data-complement bit (DQ7). It compares two successive reads of the toggle bit (DQ6). It checks the second toggle bit (DQ2) to see whether a given sector is the one being erased or suspended. A buffered program that fails sets a sticky flag (DQ1) that only an explicit clear command or reset removes. A protected-sector abort keeps the status visible for a fixed hold time before the part returns to read mode.

Top module: `wstat_report`

## Requirements
- R1: After a synchronous reset, ready is 1, status_sel is 0, dq_out equals array_data, and the DQ1 flag is 0.
- R2: While a single-word program (cmd_kind 0) is busy, every read returns the status word with bit 7 = inverse of prog_msb, bit 2 = 0, and bits other than 7, 6, 2 and 1 at 0; ready is 0.
- R3: While a buffered program (cmd_kind 2) is busy, status bit 7 is the inverse of the prog_msb given with that start (bit 7 of the last word loaded into the buffer).
- R4: While an erase (cmd_kind 1) is busy, status bit 7 is 0. Status bit 2 flips on each read whose rd_sector equals the erased sector, and holds on reads of other sectors.
- R5: Accepting a start clears both toggle bits, so the first status read after it returns bit 6 = 0. A read in the same cycle as an accepted start does not advance them. Each later read while busy flips bit 6.
- R6: The cycle after cmd_done, status_sel is 0, ready is 1, and dq_out equals array_data.
- R7: In erase-suspend, a read of the suspended sector returns bit 7 = 1 and bit 6 = 1 (not toggling), and bit 2 flips on each such read. Reads of other sectors return array_data. Ready is 1.
- R8: A program (cmd_kind 0) started in erase-suspend reports an inverted bit 7, a toggling bit 6 and ready 0. Its cmd_done returns the block to erase-suspend with the same suspended sector.
- R9: cmd_prot_abort during a busy operation holds the status word and ready 0 for HOLD_CYC cycles (default 25 at 8 ns, covering 200 ns). The block then returns to read mode, or to erase-suspend if the aborted program was started from there.
- R10: cmd_buf_abort during a buffered program sets status bit 1, keeps bit 7 inverted, bit 6 toggling and ready 0. This persists until cmd_abort_clr, after which reads return array data and the flag is 0.
- R11: cmd_start is ignored while busy or aborted, and cmd_kind 3 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Operation start pulse from the sequencer |
| cmd_kind | input | 2 | 0 program, 1 erase, 2 buffered program, 3 none |
| cmd_sector | input | SECT_W | Target sector of the started operation |
| prog_msb | input | 1 | Bit 7 of the word being programmed (last buffered word) |
| cmd_done | input | 1 | Operation completed pulse |
| cmd_prot_abort | input | 1 | Protected-sector abort pulse |
| cmd_buf_abort | input | 1 | Buffered-program abort pulse |
| cmd_abort_clr | input | 1 | Buffer-abort reset command pulse |
| cmd_suspend | input | 1 | Erase-suspend pulse |
| cmd_resume | input | 1 | Erase-resume pulse |
| rd_stb | input | 1 | Host read strobe |
| rd_sector | input | SECT_W | Sector part of the read address |
| array_data | input | DATA_W | Data read from the array |
| dq_out | output | DATA_W | Word returned to the host |
| status_sel | output | 1 | 1 when dq_out carries the status word |
| ready | output | 1 | Ready (1) / busy (0) |

## Verification
The interesting collisions are a read strobe that lands in the same cycle as a sequencer event. The bench drives a read together with an accepted start, where the clear of the toggle bits must win. It also drives a read together with cmd_done, where the status word is still shown and array data follows. A read in the cycle a protected abort or a suspend arrives is driven as well. The behavioural reference model predicts dq_out, status_sel and ready for each of these cycles, so a wrong priority shows up as a mismatch on the next sampled read.

// File: rtl/wstat_pkg.sv
// Shared types for the write-status reporting block.
package wstat_pkg;

    // Operation kind as encoded on cmd_kind.
    typedef enum logic [1:0] {
        K_PROG  = 2'd0,
        K_ERASE = 2'd1,
        K_BUF   = 2'd2,
        K_NONE  = 2'd3
    } kind_e;

    // Reporting state.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BUSY   = 3'd1,
        ST_HOLD   = 3'd2,
        ST_BABORT = 3'd3,
        ST_SUSP   = 3'd4,
        ST_SPROG  = 3'd5
    } state_e;

endpackage

// File: rtl/wstat_seq.sv
// Tracks the operation state reported to the host. It also holds the
// erased sector, the inverted polling bit, the protect-abort hold counter
// and the sticky buffer-abort flag.
// Assumes the sequencer issues at most one of done/abort/suspend per
// cycle; when several arrive, protect abort wins, then buffer abort,
// then done, then suspend.
module wstat_seq
    import wstat_pkg::*;
#(
    parameter int SECT_W   = 10,
    parameter int HOLD_CYC = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_kind,
    input  logic [SECT_W-1:0] cmd_sector,
    input  logic              prog_msb,
    input  logic              cmd_done,
    input  logic              cmd_prot_abort,
    input  logic              cmd_buf_abort,
    input  logic              cmd_abort_clr,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    output state_e            st,
    output kind_e             kind,
    output logic [SECT_W-1:0] era_sect,
    output logic              inv7,
    output logic              dq1_flag,
    output logic              start_acc
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    state_e           st_n;
    kind_e            kind_in;
    logic [CNT_W-1:0] cnt_q;
    logic             ret_susp_q;
    logic             go_hold;
    logic             go_babort;

    assign kind_in = kind_e'(cmd_kind);

    // Accept a start from read mode (any real kind) or a program from suspend.
    assign start_acc = cmd_start &&
                       ((st == ST_IDLE && kind_in != K_NONE) ||
                        (st == ST_SUSP && kind_in == K_PROG));

    assign go_hold   = cmd_prot_abort && (st == ST_BUSY || st == ST_SPROG);
    assign go_babort = !cmd_prot_abort && cmd_buf_abort &&
                       st == ST_BUSY && kind == K_BUF;

    // Next reporting state.
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:   if (start_acc) st_n = ST_BUSY;
            ST_BUSY: begin
                if (go_hold)                              st_n = ST_HOLD;
                else if (go_babort)                       st_n = ST_BABORT;
                else if (cmd_done)                        st_n = ST_IDLE;
                else if (cmd_suspend && kind == K_ERASE)  st_n = ST_SUSP;
            end
            ST_HOLD:   if (cnt_q == '0) st_n = ret_susp_q ? ST_SUSP : ST_IDLE;
            ST_BABORT: if (cmd_abort_clr) st_n = ST_IDLE;
            ST_SUSP: begin
                if (start_acc)       st_n = ST_SPROG;
                else if (cmd_resume) st_n = ST_BUSY;
            end
            ST_SPROG: begin
                if (go_hold)       st_n = ST_HOLD;
                else if (cmd_done) st_n = ST_SUSP;
            end
            default:   st_n = ST_IDLE;
        endcase
    end

    // State, kind and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            kind       <= K_NONE;
            era_sect   <= '0;
            inv7       <= 1'b0;
            ret_susp_q <= 1'b0;
        end else begin
            st <= st_n;
            if (start_acc) begin
                kind <= kind_in;
                if (kind_in == K_ERASE) era_sect <= cmd_sector;
                else                    inv7     <= ~prog_msb;
            end else if (st_n == ST_SUSP || (st == ST_SUSP && st_n == ST_BUSY)) begin
                kind <= K_ERASE;
            end
            if (go_hold) ret_susp_q <= (st == ST_SPROG);
        end
    end

    // Protect-abort hold counter: loaded on entry, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (go_hold)                     cnt_q <= CNT_W'(HOLD_CYC - 1);
        else if (st == ST_HOLD && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    // Sticky buffer-abort flag, cleared only by its command or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             dq1_flag <= 1'b0;
        else if (go_babort)     dq1_flag <= 1'b1;
        else if (cmd_abort_clr) dq1_flag <= 1'b0;
    end

endmodule

// File: rtl/wstat_toggle.sv
// The two toggle flip-flops. Both clear on an accepted start. The main
// toggle advances on each status read while an operation is active. The
// sector toggle advances only on reads of the erased or suspended sector.
// Assumes rd_hit compares the read sector with the erased sector.
module wstat_toggle
    import wstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_acc,
    input  logic   rd_stb,
    input  logic   rd_hit,
    input  state_e st,
    input  kind_e  kind,
    output logic   t6,
    output logic   t2
);
    logic active;
    logic adv6;
    logic adv2;

    assign active = (st == ST_BUSY) || (st == ST_HOLD) ||
                    (st == ST_BABORT) || (st == ST_SPROG);
    assign adv6 = rd_stb && active;
    assign adv2 = rd_stb && rd_hit &&
                  ((((st == ST_BUSY) || (st == ST_HOLD)) && kind == K_ERASE) ||
                   (st == ST_SUSP));

    // Toggle flops: clear on start, otherwise flip on qualifying reads.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            t6 <= 1'b0;
            t2 <= 1'b0;
        end else begin
            if (adv6) t6 <= ~t6;
            if (adv2) t2 <= ~t2;
        end
    end

endmodule

// File: rtl/wstat_mux.sv
// Builds the status word and selects between it and array data. Also
// derives the ready flag. Purely combinational.
module wstat_mux
    import wstat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  state_e            st,
    input  kind_e             kind,
    input  logic              rd_hit,
    input  logic              inv7,
    input  logic              t6,
    input  logic              t2,
    input  logic              dq1_flag,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              status_sel,
    output logic              ready
);
    logic              busy;
    logic [DATA_W-1:0] word;

    assign busy       = (st == ST_BUSY) || (st == ST_HOLD) ||
                        (st == ST_BABORT) || (st == ST_SPROG);
    assign status_sel = busy || (st == ST_SUSP && rd_hit);
    assign ready      = !busy;

    // Status word assembly; unused bit positions read 0.
    always_comb begin
        word    = '0;
        word[7] = (st == ST_SUSP) ? 1'b1 : ((kind == K_ERASE) ? 1'b0 : inv7);
        word[6] = (st == ST_SUSP) ? 1'b1 : t6;
        word[2] = t2;
        word[1] = dq1_flag;
    end

    assign dq_out = status_sel ? word : array_data;

endmodule

// File: rtl/wstat_report.sv
// Top of the write-status reporting block: ties the state tracker, the
// toggle flops and the output mux together.
// Assumes DATA_W >= 8 and a sequencer that drives one-cycle command pulses.
module wstat_report
    import wstat_pkg::*;
#(
    parameter int SECT_W   = 10,
    parameter int DATA_W   = 16,
    parameter int CLK_PS   = 8000,
    parameter int HOLD_PS  = 200000,
    parameter int HOLD_CYC = (HOLD_PS + CLK_PS - 1) / CLK_PS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_kind,
    input  logic [SECT_W-1:0] cmd_sector,
    input  logic              prog_msb,
    input  logic              cmd_done,
    input  logic              cmd_prot_abort,
    input  logic              cmd_buf_abort,
    input  logic              cmd_abort_clr,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    input  logic              rd_stb,
    input  logic [SECT_W-1:0] rd_sector,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              status_sel,
    output logic              ready
);
    state_e            st_q;
    kind_e             kind_q;
    logic [SECT_W-1:0] era_sect;
    logic              inv7;
    logic              dq1_flag;
    logic              start_acc;
    logic              rd_hit;
    logic              t6;
    logic              t2;

    assign rd_hit = (rd_sector == era_sect);

    wstat_seq #(.SECT_W(SECT_W), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_kind(cmd_kind), .cmd_sector(cmd_sector),
        .prog_msb(prog_msb), .cmd_done(cmd_done),
        .cmd_prot_abort(cmd_prot_abort), .cmd_buf_abort(cmd_buf_abort),
        .cmd_abort_clr(cmd_abort_clr), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume),
        .st(st_q), .kind(kind_q), .era_sect(era_sect), .inv7(inv7),
        .dq1_flag(dq1_flag), .start_acc(start_acc)
    );

    wstat_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .rd_stb(rd_stb),
        .rd_hit(rd_hit), .st(st_q), .kind(kind_q), .t6(t6), .t2(t2)
    );

    wstat_mux #(.DATA_W(DATA_W)) u_mux (
        .st(st_q), .kind(kind_q), .rd_hit(rd_hit), .inv7(inv7), .t6(t6),
        .t2(t2), .dq1_flag(dq1_flag), .array_data(array_data),
        .dq_out(dq_out), .status_sel(status_sel), .ready(ready)
    );

endmodule

// File: rtl/wstat_report_chk.sv
// Property checker for wstat_report, attached with bind below.
module wstat_report_chk
    import wstat_pkg::*;
#(
    parameter int HOLD_CYC = 25
) (
    input logic   clk,
    input logic   rst_n,
    input state_e st,
    input kind_e  kind,
    input logic   cmd_start,
    input logic   cmd_done,
    input logic   cmd_prot_abort,
    input logic   cmd_buf_abort,
    input logic   cmd_suspend,
    input logic   cmd_abort_clr,
    input logic   rd_stb,
    input logic   dq7,
    input logic   dq6,
    input logic   dq1,
    input logic   status_sel,
    input logic   ready
);
    localparam int HC_W = $clog2(HOLD_CYC + 2);

    logic            any_cmd;
    logic [HC_W-1:0] hold_len;

    assign any_cmd = cmd_start || cmd_done || cmd_prot_abort ||
                     cmd_buf_abort || cmd_suspend;

    // Counts consecutive cycles spent in the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_HOLD) hold_len <= '0;
        else                         hold_len <= hold_len + 1'b1;
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> !ready); // R2

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && kind == K_ERASE && status_sel) |-> !dq7); // R4

    AST_DQ6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && rd_stb && !any_cmd) |=>
        ((st == ST_BUSY && rd_stb) -> (dq6 != $past(dq6)))); // R5

    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |-> ready); // R7

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (hold_len < HC_W'(HOLD_CYC))); // R9

    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && hold_len == HC_W'(HOLD_CYC - 1)) |=> (st != ST_HOLD)); // R9

    AST_DQ1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_sel && dq1 && !cmd_abort_clr) |=> (status_sel && dq1 && !ready)); // R10

endmodule

bind wstat_report wstat_report_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_q), .kind(kind_q),
    .cmd_start(cmd_start), .cmd_done(cmd_done),
    .cmd_prot_abort(cmd_prot_abort), .cmd_buf_abort(cmd_buf_abort),
    .cmd_suspend(cmd_suspend), .cmd_abort_clr(cmd_abort_clr),
    .rd_stb(rd_stb), .dq7(dq_out[7]), .dq6(dq_out[6]), .dq1(dq_out[1]),
    .status_sel(status_sel), .ready(ready)
);

// File: tb/sim_wstat_report.sv
`timescale 1ns/1ps
module sim_wstat_report;
    localparam int SW = 10;
    localparam int DW = 16;
    localparam int HC = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, prog_msb = 0, cmd_done = 0, cmd_prot_abort = 0;
    logic cmd_buf_abort = 0, cmd_abort_clr = 0, cmd_suspend = 0, cmd_resume = 0;
    logic rd_stb = 0;
    logic [1:0]    cmd_kind = 0;
    logic [SW-1:0] cmd_sector = 0;
    logic [SW-1:0] rd_sector = 0;
    logic [DW-1:0] array_data = 16'h5A3C;
    wire  [DW-1:0] dq_out;
    wire           status_sel;
    wire           ready;

    always #4 clk = ~clk;

    wstat_report u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
        .cmd_sector(cmd_sector), .prog_msb(prog_msb), .cmd_done(cmd_done),
        .cmd_prot_abort(cmd_prot_abort), .cmd_buf_abort(cmd_buf_abort),
        .cmd_abort_clr(cmd_abort_clr), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .rd_stb(rd_stb), .rd_sector(rd_sector),
        .array_data(array_data), .dq_out(dq_out), .status_sel(status_sel),
        .ready(ready)
    );

    int checks = 0;
    int fails  = 0;
    string req = "R1";

    // Reference model: 0 read, 1 busy, 2 hold, 3 buffer abort, 4 suspend, 5 program-in-suspend
    int m_st = 0, m_kind = 3, m_sect = 0, m_inv7 = 0, m_dq1 = 0;
    int m_t6 = 0, m_t2 = 0, m_cnt = 0, m_ret = 0;

    task automatic check(string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic bit m_busy();
        return (m_st == 1 || m_st == 2 || m_st == 3 || m_st == 5);
    endfunction

    function automatic logic [DW-1:0] m_dq();
        logic [DW-1:0] w;
        bit hit = (int'(rd_sector) == m_sect);
        if (!(m_busy() || (m_st == 4 && hit))) return array_data;
        w = '0;
        w[7] = (m_st == 4) ? 1'b1 : ((m_kind == 1) ? 1'b0 : m_inv7[0]);
        w[6] = (m_st == 4) ? 1'b1 : m_t6[0];
        w[2] = m_t2[0];
        w[1] = m_dq1[0];
        return w;
    endfunction

    task automatic model_step();
        int  st0 = m_st;
        bit  hit = (int'(rd_sector) == m_sect);
        bit  acc = cmd_start && ((st0 == 0 && cmd_kind != 3) || (st0 == 4 && cmd_kind == 0));
        if (!rst_n) begin
            m_st = 0; m_kind = 3; m_sect = 0; m_inv7 = 0; m_dq1 = 0;
            m_t6 = 0; m_t2 = 0; m_cnt = 0; m_ret = 0;
            return;
        end
        if (acc) begin m_t6 = 0; m_t2 = 0; end
        else if (rd_stb) begin
            if (st0 == 1 || st0 == 2 || st0 == 3 || st0 == 5) m_t6 ^= 1;
            if (hit && (((st0 == 1 || st0 == 2) && m_kind == 1) || st0 == 4)) m_t2 ^= 1;
        end
        if (st0 == 1 && !cmd_prot_abort && cmd_buf_abort && m_kind == 2) m_dq1 = 1;
        else if (cmd_abort_clr) m_dq1 = 0;
        if (acc) begin
            if (cmd_kind == 1) m_sect = int'(cmd_sector);
            else               m_inv7 = prog_msb ? 0 : 1;
        end
        case (st0)
            0: if (acc) begin m_st = 1; m_kind = cmd_kind; end
            1: if (cmd_prot_abort) begin m_st = 2; m_cnt = HC - 1; m_ret = 0; end
               else if (cmd_buf_abort && m_kind == 2) m_st = 3;
               else if (cmd_done) m_st = 0;
               else if (cmd_suspend && m_kind == 1) m_st = 4;
            2: if (m_cnt == 0) begin m_st = m_ret ? 4 : 0; if (m_ret) m_kind = 1; end
               else m_cnt--;
            3: if (cmd_abort_clr) m_st = 0;
            4: if (acc) begin m_st = 5; m_kind = 0; end
               else if (cmd_resume) begin m_st = 1; m_kind = 1; end
            5: if (cmd_prot_abort) begin m_st = 2; m_cnt = HC - 1; m_ret = 1; end
               else if (cmd_done) begin m_st = 4; m_kind = 1; end
            default: m_st = 0;
        endcase
    endtask

    // One clock: compare outputs with the model, advance both, clear pulses.
    task automatic cycle();
        #1;
        check(req, "status_sel", status_sel, (m_busy() || (m_st == 4 && int'(rd_sector) == m_sect)));
        check(req, "ready", ready, !m_busy());
        check(req, "dq_out", dq_out, m_dq());
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmd_start = 0; cmd_done = 0; cmd_prot_abort = 0; cmd_buf_abort = 0;
        cmd_abort_clr = 0; cmd_suspend = 0; cmd_resume = 0; rd_stb = 0;
        array_data = array_data + 16'h1357;
    endtask

    task automatic start_op(int k, int s, bit msb);
        cmd_start = 1; cmd_kind = 2'(k); cmd_sector = SW'(s); prog_msb = msb;
        cycle();
    endtask

    task automatic rd(int s);
        rd_stb = 1; rd_sector = SW'(s);
        cycle();
    endtask

    // Read with an explicit expected value of one status bit.
    task automatic rd_bit(int s, int b, bit e, string r);
        rd_stb = 1; rd_sector = SW'(s);
        #1 check(r, $sformatf("dq[%0d]", b), dq_out[b], e);
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        cycle();
        rst_n = 1;
        // R1: reset state
        req = "R1";
        rd(3);
        #1 check("R1", "ready", ready, 1'b1);
        check("R1", "status_sel", status_sel, 1'b0);

        // R2 / R5: single-word program, bit 7 of word = 1
        req = "R2";
        start_op(0, 3, 1'b1);
        rd_bit(3, 7, 1'b0, "R2");
        rd_bit(9, 6, 1'b1, "R5");
        rd_bit(3, 6, 1'b0, "R5");
        rd_bit(3, 2, 1'b0, "R2");
        // R11: start while busy is ignored
        req = "R11";
        start_op(1, 7, 1'b0);
        rd(3);
        // R6: completion with a read in the same cycle
        req = "R6";
        cmd_done = 1; rd_stb = 1; rd_sector = 3; cycle();
        rd(3);
        rd(3);

        // R11: kind 3 never accepted
        req = "R11";
        start_op(3, 2, 1'b0);
        rd(2);

        // R3 / R10: buffered program, last word bit 7 = 0
        req = "R3";
        start_op(2, 4, 1'b0);
        rd_bit(4, 7, 1'b1, "R3");
        rd(4);
        req = "R10";
        cmd_buf_abort = 1; rd_stb = 1; rd_sector = 4; cycle();
        rd_bit(4, 1, 1'b1, "R10");
        rd(1);
        start_op(0, 4, 1'b1);
        rd_bit(4, 7, 1'b1, "R10");
        rd(4);
        cmd_abort_clr = 1; cycle();
        rd(4);
        rd(4);

        // R4 / R5: erase, start coincides with a read
        req = "R4";
        cmd_start = 1; cmd_kind = 1; cmd_sector = 5; rd_stb = 1; rd_sector = 5; cycle();
        rd_bit(5, 6, 1'b0, "R5");
        rd_bit(5, 2, 1'b1, "R4");
        rd_bit(2, 2, 1'b0, "R4");
        rd_bit(2, 2, 1'b0, "R4");
        rd_bit(5, 7, 1'b0, "R4");
        rd(5);
        // R7: suspend
        req = "R7";
        cmd_suspend = 1; rd_stb = 1; rd_sector = 5; cycle();
        rd_bit(5, 6, 1'b1, "R7");
        rd_bit(5, 6, 1'b1, "R7");
        rd(2);
        rd(5);
        rd(5);
        // R8: program inside suspend, bit 7 = 0
        req = "R8";
        start_op(0, 2, 1'b0);
        rd_bit(2, 7, 1'b1, "R8");
        rd(5);
        rd(2);
        cmd_done = 1; cycle();
        rd(5);
        rd(2);
        // R9: protect abort of a program in suspend returns to suspend
        req = "R9";
        start_op(0, 6, 1'b1);
        rd(6);
        cmd_prot_abort = 1; rd_stb = 1; rd_sector = 6; cycle();
        for (int i = 0; i < HC + 3; i++) rd((i % 2 == 0) ? 5 : 6);
        // resume, then protect abort during erase returns to read mode
        cmd_resume = 1; cycle();
        rd(5);
        rd(1);
        cmd_prot_abort = 1; cycle();
        for (int i = 0; i < HC + 3; i++) rd((i % 3 == 0) ? 5 : 1);
        req = "R6";
        rd(5);
        // reset clears state
        req = "R1";
        start_op(2, 8, 1'b1);
        cmd_buf_abort = 1; cycle();
        rst_n = 0; cycle();
        rst_n = 1;
        rd(8);
        #1 check("R1", "ready", ready, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule